// File: doc/BRIEF.md
# Comma-Aligned Word Deserializer

This block turns a serial bit stream into 10-bit parallel words. It runs in the bit-rate clock domain and takes one bit on each cycle where the bit-enable input is high. It keeps a sliding window of the last ten bits and looks for a comma, which is a fixed seven-bit start pattern. While synchronisation is enabled, a comma seen at a new bit offset moves the word boundary at once, so that the comma word is presented with its first bit in bit 0. While synchronisation is disabled, the boundary found earlier is held and no comma is ever reported.

Along with each parallel word the block drives two complementary word clocks, made as registered signals in the bit domain. A rate input picks the clock rate: full rate (one word-clock cycle per word) or half rate (words presented alternately on the rising edges of the two clocks). A comma flag marks words that are both commas and presented on a rising edge of word clock 0. A loopback select chooses between the external serial input and an internal transmit-side serial stream.

Top module: `comma_deser`

## Requirements
- R1: Output bit 0 of `word_out` holds the earliest received bit of the word and bit 9 the latest. A comma is a word whose received bits 0..6 are 0,0,1,1,1,1,1, so a comma followed by the bits 0,1,0 appears as `word_out` = 10'h17C.
- R2: While `sync_en` is high, the bit that completes a comma at any of the ten offsets makes `word_out` show that comma in the same cycle. Later words then follow every 10 bits from that boundary.
- R3: While `sync_en` is low, words are presented every 10 bits at the boundary already held, whatever the data.
- R4: While `sync_en` is low, `comma_flag` is low from the next clock cycle onward.
- R5: `comma_flag` rises only together with a rising edge of `wclk0`, on a comma word. It falls together with the next falling edge of `wclk0`: 5 bits later at full rate, 10 bits later at half rate.
- R6: With `rate_full` high, `wclk0` goes high on each word boundary and low 5 bits after it.
- R7: With `rate_full` low, `wclk0` toggles on each word boundary. When a comma is found while `wclk0` is high, `wclk0` stays high instead, so the following commas land on `wclk0` rising edges.
- R8: `wclk1` is always the logical inverse of `wclk0`.
- R9: With `loop_sel` low the block takes its bits from `ser_in`. With `loop_sel` high it takes them from `lpbk_in`.
- R10: During reset `word_out` = 0, `comma_flag` = 0, `wclk0` = 0, `wclk1` = 1, and the boundary counter starts at zero.
- R11: A cycle with `bit_en` low changes neither the word, the word clocks nor the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One serial bit is taken on this cycle |
| ser_in | input | 1 | External serial bit |
| lpbk_in | input | 1 | Internal transmit-side serial bit |
| loop_sel | input | 1 | 1 selects `lpbk_in` |
| rate_full | input | 1 | 1: word clocks at 1/10 bit rate; 0: at 1/20 |
| sync_en | input | 1 | 1 allows realignment and the comma flag |
| word_out | output | 10 | Aligned parallel word, bit 0 received first |
| comma_flag | output | 1 | Comma on a `wclk0` rising edge |
| wclk0 | output | 1 | Word clock |
| wclk1 | output | 1 | Complement of `wclk0` |

## Verification
Every output is registered off the edge that takes the bit, so the word, the flag and both clocks are due in the very cycle whose `bit_en` carries the tenth bit of a word, or the fifth bit after a boundary for the full-rate clock fall. The bench drives each bit on a falling edge and samples at the next falling edge, after the one rising edge that takes the bit. With idle gaps between bits it samples only after the gap, which also shows that the idle cycles changed nothing. The expected words are cut from the bench's own record of the bits it sent, counted from the bit where the comma completes.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
  localparam int WORD_W    = 10;
  localparam int COMMA_LEN = 7;
  // received order: bit0 first -> 0,0,1,1,1,1,1
  localparam logic [COMMA_LEN-1:0] COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/cd_bit_window.sv
module cd_bit_window #(
  parameter int W  = 10,
  parameter int CL = 7,
  parameter logic [CL-1:0] PAT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         ext_bit,
  input  logic         lpbk_bit,
  input  logic         loop_sel,
  output logic [W-1:0] win_next,
  output logic         comma_hit
);
  logic [W-1:0]  win_q;
  logic [CL-1:0] bit_ok;
  logic          sel_bit;

  // R9: source select
  assign sel_bit = loop_sel ? lpbk_bit : ext_bit;

  // newest bit enters at the top, oldest sits at bit 0 (R1)
  always_comb begin
    win_next = win_q;
    if (bit_en) win_next = {sel_bit, win_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_next;
  end

  generate
    for (genvar i = 0; i < CL; i++) begin : g_cmp
      assign bit_ok[i] = (win_next[i] == PAT[i]);
    end
  endgenerate

  assign comma_hit = bit_en & (&bit_ok);

  // R11: no bit, no shift
  a_r11_window_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(win_q));
endmodule

// File: rtl/cd_boundary.sv
module cd_boundary #(
  parameter int W  = 10,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          sync_en,
  input  logic          comma_hit,
  output logic          word_done,
  output logic [CW-1:0] cnt_next
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end    = (cnt_q == LAST);
  assign word_done = bit_en & (at_end | (sync_en & comma_hit));

  always_comb begin
    cnt_next = cnt_q;
    if (bit_en) begin
      if (word_done) cnt_next = '0;
      else           cnt_next = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  // R2: counter stays inside one word
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R3: frozen boundary just counts on
  a_r3_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !sync_en && !at_end) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/cd_word_clock.sv
module cd_word_clock #(
  parameter int W  = 10,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rate_full,
  input  logic          sync_en,
  input  logic          word_done,
  input  logic          comma_hit,
  input  logic [CW-1:0] cnt_next,
  output logic          wclk0,
  output logic          wclk1,
  output logic          flag
);
  localparam logic [CW-1:0] HALF = CW'(W / 2);

  logic w0_q, w0_next, w1_q, flag_q, flag_next;
  logic comma_sync, full_fall;

  assign comma_sync = sync_en & comma_hit;
  assign full_fall  = bit_en & rate_full & (cnt_next == HALF);

  always_comb begin
    w0_next = w0_q;
    if (word_done) begin
      if (rate_full)       w0_next = 1'b1;
      else if (comma_sync) w0_next = 1'b1;      // R7 slip
      else                 w0_next = ~w0_q;
    end else if (full_fall) begin
      w0_next = 1'b0;
    end
  end

  always_comb begin
    flag_next = flag_q;
    if (!sync_en)        flag_next = 1'b0;
    else if (word_done)  flag_next = comma_hit & ~w0_q;
    else if (full_fall)  flag_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q   <= 1'b0;
      w1_q   <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      w0_q   <= w0_next;
      w1_q   <= ~w0_next;
      flag_q <= flag_next;
    end
  end

  assign wclk0 = w0_q;
  assign wclk1 = w1_q;
  assign flag  = flag_q;

  a_r8_clk_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    w1_q == ~w0_q);
  a_r4_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> !flag_q);
  a_r5_flag_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $rose(w0_q));
  a_r6_full_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rate_full) |=> w0_q);
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import comma_deser_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CL = COMMA_LEN,
  parameter logic [CL-1:0] PAT = COMMA_PAT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         ser_in,
  input  logic         lpbk_in,
  input  logic         loop_sel,
  input  logic         rate_full,
  input  logic         sync_en,
  output logic [W-1:0] word_out,
  output logic         comma_flag,
  output logic         wclk0,
  output logic         wclk1
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  win_next, word_q;
  logic          comma_hit, word_done;
  logic [CW-1:0] cnt_next;

  cd_bit_window #(.W(W), .CL(CL), .PAT(PAT)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ext_bit(ser_in),
    .lpbk_bit(lpbk_in), .loop_sel(loop_sel),
    .win_next(win_next), .comma_hit(comma_hit)
  );

  cd_boundary #(.W(W), .CW(CW)) u_bnd (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sync_en(sync_en),
    .comma_hit(comma_hit), .word_done(word_done), .cnt_next(cnt_next)
  );

  cd_word_clock #(.W(W), .CW(CW)) u_clk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rate_full(rate_full),
    .sync_en(sync_en), .word_done(word_done), .comma_hit(comma_hit),
    .cnt_next(cnt_next), .wclk0(wclk0), .wclk1(wclk1), .flag(comma_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (word_done) word_q <= win_next;
  end

  assign word_out = word_q;

  a_r11_word_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(word_q));
  a_r2_comma_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && comma_hit) |=> (word_q[CL-1:0] == PAT));
endmodule

// File: tb/tb_comma_deser.sv
module tb_comma_deser;
  localparam int TCLK = 10;
  localparam logic [9:0] COMMA = 10'h17C;
  localparam logic [9:0] DATA  = 10'h155;
  // {gap, loop, sync, full, off[3:0]}
  localparam logic [7:0] VEC [0:26] = '{
    8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39,
    8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27, 8'h28, 8'h29,
    8'h13, 8'h07, 8'h10, 8'h74, 8'h62, 8'hB5, 8'hE8};

  logic clk = 0, rst_n = 0, bit_en = 0, ser_in = 1, lpbk_in = 1;
  logic loop_sel = 0, rate_full = 1, sync_en = 1;
  logic [9:0] word_out;
  logic comma_flag, wclk0, wclk1;

  int checks = 0, fails = 0, n = 0, inv_bad = 0, rises = 0;
  logic hist [0:1023];
  logic gap_mode = 0, flag_seen = 0, prev_w0 = 0;

  comma_deser dut (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
    .lpbk_in(lpbk_in), .loop_sel(loop_sel), .rate_full(rate_full),
    .sync_en(sync_en), .word_out(word_out), .comma_flag(comma_flag),
    .wclk0(wclk0), .wclk1(wclk1));

  always #(TCLK/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(TCLK * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_en = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1; n = 0; inv_bad = 0; flag_seen = 0; rises = 0; prev_w0 = 0;
    @(negedge clk);
  endtask

  task automatic put(input logic b);
    hist[n] = b; n++;
    if (loop_sel) begin lpbk_in = b; ser_in = 1'b1; end
    else          begin ser_in = b;  lpbk_in = 1'b1; end
    bit_en = 1;
    @(negedge clk);
    bit_en = 0;
    if (gap_mode) begin ser_in = ~ser_in; @(negedge clk); end
    if (wclk1 !== ~wclk0) inv_bad++;
    if (comma_flag) flag_seen = 1;
    if (!prev_w0 && wclk0) rises++;
    prev_w0 = wclk0;
  endtask

  task automatic put_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) put(w[i]);
  endtask

  function automatic logic [9:0] win_at(input int e);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = hist[e - 10 + i];
    return r;
  endfunction

  initial begin
    // R10: reset state
    do_reset();
    chk(word_out == 10'h0, "R10 word", word_out, 0);
    chk(comma_flag == 0, "R10 flag", comma_flag, 0);
    chk(wclk0 == 0 && wclk1 == 1, "R10 clocks", {wclk0, wclk1}, 1);

    // table walk
    for (int v = 0; v < 27; v++) begin
      logic [7:0] e;
      int off, p, hb;
      logic full, sy, lp, gp, expf;
      logic fok;
      e = VEC[v];
      off = int'(e[3:0]); full = e[4]; sy = e[5]; lp = e[6]; gp = e[7];
      loop_sel = lp; rate_full = full; sync_en = sy; gap_mode = gp;
      do_reset();
      for (int i = 0; i < off; i++) put(1'b0);
      put_word(COMMA);
      p = n;
      if (sy) begin
        expf = (off == 0) || (full && off >= 6);
        chk(word_out == COMMA, lp ? "R9 loop comma" : "R2 align", word_out, COMMA);
        chk(comma_flag == expf, "R5 first flag", comma_flag, expf);
        chk(wclk0 == 1, full ? "R6 rise" : "R7 slip high", wclk0, 1);
        put_word(DATA);
        chk(word_out == DATA, "R2 next word", word_out, DATA);
        chk(wclk0 == full, full ? "R6 next rise" : "R7 toggle", wclk0, full);
        put_word(COMMA);
        chk(word_out == COMMA && comma_flag == 1, "R5 second comma",
            {word_out, comma_flag}, {COMMA, 1'b1});
        hb = full ? 5 : 10;
        fok = 1;
        for (int k = 1; k <= 10; k++) begin
          put(DATA[k-1]);
          if (k < hb && !comma_flag) fok = 0;
          if (k == hb && (comma_flag || wclk0)) fok = 0;
        end
        chk(fok, "R5 flag width", fok, 1);
        chk(word_out == DATA, "R1 data order", word_out, DATA);
      end else begin
        put_word(DATA);
        put_word(COMMA);
        while (n % 10 != 0) put(DATA[n % 2]);
        chk(word_out == win_at(n), "R3 held boundary", word_out, win_at(n));
        chk(!flag_seen, "R4 flag low", flag_seen, 0);
      end
      chk(inv_bad == 0, "R8 inverse", inv_bad, 0);
      if (p < 0) $display("unreachable");
    end

    // R3/R4: freeze after alignment
    loop_sel = 0; rate_full = 1; sync_en = 1; gap_mode = 0;
    do_reset();
    for (int i = 0; i < 3; i++) put(1'b0);
    put_word(COMMA); put_word(DATA); put_word(COMMA);
    chk(comma_flag == 1, "R5 before freeze", comma_flag, 1);
    @(negedge clk); sync_en = 0;
    @(negedge clk);
    chk(comma_flag == 0, "R4 flag cleared", comma_flag, 0);
    put(1'b0); put(1'b1); put(1'b0); put(1'b1);
    put_word(COMMA);
    chk(word_out == win_at(n - 4), "R3 no realign", word_out, win_at(n - 4));
    flag_seen = 0;
    put_word(DATA);
    chk(word_out == win_at(n - 4) && word_out != COMMA, "R3 old boundary",
        word_out, win_at(n - 4));
    chk(!flag_seen, "R4 no flag", flag_seen, 0);

    // R11: idle cycles
    begin
      logic [9:0] w; logic c0;
      w = word_out; c0 = wclk0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk); ser_in = ~ser_in;
      end
      chk(word_out == w && wclk0 == c0, "R11 idle", {word_out, wclk0}, {w, c0});
    end

    // R6/R7: clock rate
    for (int m = 0; m < 2; m++) begin
      rate_full = (m == 0); sync_en = 1;
      do_reset();
      put_word(COMMA);
      rises = 0; prev_w0 = wclk0;
      for (int i = 0; i < 4; i++) put_word(DATA);
      chk(rises == (m == 0 ? 4 : 2), m == 0 ? "R6 rate" : "R7 rate",
          rises, m == 0 ? 4 : 2);
    end

    // R10: reset during activity
    rate_full = 1;
    put(1'b1);
    rst_n = 0;
    @(negedge clk);
    chk(word_out == 0 && comma_flag == 0 && wclk0 == 0 && wclk1 == 1,
        "R10 async reset", {word_out, comma_flag, wclk0, wclk1}, 1);
    rst_n = 1;
    summary();
  end
endmodule